// File: doc/BRIEF.md
# SPI Receive Status and Interrupt Controller

This block sits next to the serial shifter of an SPI peripheral. It owns the receive side's register state. When the shifter reports a finished byte, the block moves that byte into a receive holding register and raises a receive-full flag. A second byte that arrives before software has emptied the holding register raises an overflow flag, and that byte is dropped. While overflow stays set, every later byte is dropped too. A mode-fault detector pulse can set a third flag, but only while mode-fault detection is enabled.

Software clears a flag with an ordered pair of accesses. First it reads the status register while the flag is set, which arms the clear. Then it reads the data register to clear receive-full or overflow, or writes the control register to clear mode-fault. Any one status read arms only the flags it saw set.

The flags drive one registered CPU interrupt line that is shared by the receive and error sources. When DMA service is selected, receive-full instead drives a registered DMA request.

Top module: `spi_rx_status`

## Requirements
- R1: When `byte_done` pulses while `rx_full` and `ovr` are both 0, `rx_data` takes `byte_in` and `rx_full` reads 1 after the next rising edge.
- R2: When `byte_done` pulses while `rx_full` is 1, `ovr` is 0 and no clearing data read happens in the same cycle, `ovr` becomes 1 and `rx_data` keeps its earlier byte.
- R3: While `ovr` is 1 and not being cleared, a `byte_done` pulse leaves `rx_full` and `rx_data` unchanged, so the byte is lost.
- R4: A `data_rd` clears `rx_full` only if an earlier `stat_rd` saw `rx_full` at 1 with no `data_rd` in between. Every `data_rd` consumes the arming. A `data_rd` with no arming status read has no effect.
- R5: A `data_rd` clears `ovr` only if the arming `stat_rd` saw `ovr` at 1. If overflow arose after the status read, the data read clears `rx_full` but leaves `ovr` set.
- R6: `fault_det` sets `fault` only while `fault_en` is 1. While `fault_en` is 0, `fault` reads 0.
- R7: A `ctrl_wr` clears `fault` only after a `stat_rd` that saw `fault` at 1. A `ctrl_wr` with no such status read has no effect.
- R8: One cycle after the flags and enables hold, `cpu_irq` equals (`rx_full` AND `rx_ie` AND NOT `dma_sel`) OR ((`ovr` OR `fault`) AND `err_ie`). A single enable, `err_ie`, gates both error sources.
- R9: One cycle after the flags and enables hold, `dma_req` equals `rx_full` AND `rx_ie` AND `dma_sel`.
- R10: When `byte_done` coincides with a clearing `data_rd`, the new byte is captured, `rx_full` stays 1 and `ovr` stays 0.
- R11: Synchronous reset `rst` drives every flag, `rx_data`, `cpu_irq` and `dma_req` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_done | input | 1 | One-cycle strobe: shifter finished a byte |
| byte_in | input | DATA_W | Byte from the shift register |
| fault_det | input | 1 | One-cycle mode-fault detect pulse |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ctrl_wr | input | 1 | Control register write strobe |
| rx_ie | input | 1 | Receive-full interrupt enable |
| err_ie | input | 1 | Shared error interrupt enable (overflow and mode-fault) |
| dma_sel | input | 1 | Route receive-full to DMA instead of CPU |
| fault_en | input | 1 | Mode-fault detection enable |
| rx_data | output | DATA_W | Receive holding register |
| rx_full | output | 1 | Receive-full flag |
| ovr | output | 1 | Overflow flag |
| fault | output | 1 | Mode-fault flag |
| cpu_irq | output | 1 | Shared receiver/error interrupt request |
| dma_req | output | 1 | Receive DMA request |

## Verification
The bench runs a missed-overflow case, in which an overflow lands between the status read and the data read. A design that cleared overflow on every data read would accept the following byte, which should be dropped. The bench issues bare data reads and control writes with no status read before them; a design that ignored the arming would clear the flags early. It also collides a byte completion with a clearing data read. A design that put the clear first would report an overflow here, or drop the byte. Routing checks confirm that receive-full leaves the CPU line once DMA is selected, and that a mode-fault pulse with detection disabled never shows up.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef struct packed {
    logic full;
    logic ovr;
    logic fault;
  } rx_flags_t;
endpackage

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr
);
  logic full_q, ovr_q, full_arm, ovr_arm;
  logic [DATA_W-1:0] data_q;
  logic full_eff, ovr_eff;

  // flag value after any clear armed by an earlier status read
  always_comb begin
    full_eff = full_q & ~(data_rd & full_arm);
    ovr_eff  = ovr_q  & ~(data_rd & ovr_arm);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      full_arm <= 1'b0;
      ovr_arm  <= 1'b0;
      data_q   <= '0;
    end else begin
      if (stat_rd) begin
        full_arm <= full_q;
        ovr_arm  <= ovr_q;
      end else if (data_rd) begin
        full_arm <= 1'b0;
        ovr_arm  <= 1'b0;
      end
      full_q <= full_eff;
      ovr_q  <= ovr_eff;
      // capture wins over a coincident clear; overflow blocks all capture
      if (byte_done && !ovr_eff) begin
        if (full_eff) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= byte_in;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign ovr     = ovr_q;
endmodule

// File: rtl/spi_fault_flag.sv
module spi_fault_flag (
  input  logic clk,
  input  logic rst,
  input  logic fault_det,
  input  logic fault_en,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic fault
);
  logic fault_q, fault_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= 1'b0;
      fault_arm <= 1'b0;
    end else begin
      if (stat_rd)      fault_arm <= fault_q;
      else if (ctrl_wr) fault_arm <= 1'b0;

      if (!fault_en)                  fault_q <= 1'b0;
      else if (fault_det)             fault_q <= 1'b1;
      else if (ctrl_wr && fault_arm)  fault_q <= 1'b0;
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/spi_irq_route.sv
module spi_irq_route
  import spi_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rx_flags_t flags,
  input  logic      rx_ie,
  input  logic      err_ie,
  input  logic      dma_sel,
  output logic      cpu_irq,
  output logic      dma_req
);
  logic rx_src, err_src;

  always_comb begin
    rx_src  = flags.full & rx_ie;
    err_src = (flags.ovr | flags.fault) & err_ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_irq <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      cpu_irq <= (rx_src & ~dma_sel) | err_src;
      dma_req <= rx_src & dma_sel;
    end
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              fault_det,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  input  logic              rx_ie,
  input  logic              err_ie,
  input  logic              dma_sel,
  input  logic              fault_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              ovr,
  output logic              fault,
  output logic              cpu_irq,
  output logic              dma_req
);
  rx_flags_t flags;

  spi_rx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_in(byte_in),
    .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .rx_full(rx_full), .ovr(ovr)
  );

  spi_fault_flag u_flt (
    .clk(clk), .rst(rst), .fault_det(fault_det), .fault_en(fault_en),
    .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .fault(fault)
  );

  always_comb begin
    flags.full  = rx_full;
    flags.ovr   = ovr;
    flags.fault = fault;
  end

  spi_irq_route u_irq (
    .clk(clk), .rst(rst), .flags(flags), .rx_ie(rx_ie), .err_ie(err_ie),
    .dma_sel(dma_sel), .cpu_irq(cpu_irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_done,
  input logic [DATA_W-1:0] byte_in,
  input logic              fault_det,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              ctrl_wr,
  input logic              rx_ie,
  input logic              err_ie,
  input logic              dma_sel,
  input logic              fault_en,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              ovr,
  input logic              fault,
  input logic              cpu_irq,
  input logic              dma_req
);
  p_overflow_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !ovr && byte_done && !data_rd) |=> (ovr && $stable(rx_data)));

  p_blocked_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (ovr && !data_rd && byte_done) |=> ($stable(rx_data) && $stable(rx_full) && ovr));

  p_ovr_needs_read_r5: assert property (@(posedge clk) disable iff (rst)
    (ovr && !data_rd) |=> ovr);

  p_fault_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !fault_en |=> !fault);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!rx_ie && !err_ie) |=> !cpu_irq);

  p_dma_route_r9: assert property (@(posedge clk) disable iff (rst)
    (dma_sel && !ovr && !fault) |=> !cpu_irq);

  p_dma_off_r9: assert property (@(posedge clk) disable iff (rst)
    !dma_sel |=> !dma_req);
endmodule

bind spi_rx_status spi_rx_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/spi_rx_status_bench.sv
module spi_rx_status_bench;
  localparam int DATA_W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_done = 0, fault_det = 0, stat_rd = 0, data_rd = 0, ctrl_wr = 0;
  logic rx_ie = 0, err_ie = 0, dma_sel = 0, fault_en = 0;
  logic [DATA_W-1:0] byte_in = '0;
  logic [DATA_W-1:0] rx_data;
  logic rx_full, ovr, fault, cpu_irq, dma_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_rx_status #(.DATA_W(DATA_W)) u_spi_rx_status (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic put_byte(input logic [DATA_W-1:0] b);
    byte_in = b; byte_done = 1; tick(); byte_done = 0;
  endtask
  task automatic rd_stat(); stat_rd = 1; tick(); stat_rd = 0; endtask
  task automatic rd_data(); data_rd = 1; tick(); data_rd = 0; endtask
  task automatic wr_ctrl(); ctrl_wr = 1; tick(); ctrl_wr = 0; endtask

  task automatic do_reset();
    rst = 1; rx_ie = 0; err_ie = 0; dma_sel = 0; fault_en = 0;
    repeat (2) tick();
    rst = 0; tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 rx_full", rx_full, 0);
    check("R11 ovr", ovr, 0);
    check("R11 fault", fault, 0);
    check("R11 rx_data", rx_data, 0);
    check("R11 cpu_irq", cpu_irq, 0);
    check("R11 dma_req", dma_req, 0);
  endtask

  task automatic t_capture_clear();
    do_reset();
    put_byte(8'hA5);
    check("R1 full", rx_full, 1);
    check("R1 data", rx_data, 8'hA5);
    rd_data();
    check("R4 bare data read keeps full", rx_full, 1);
    rd_stat(); rd_data();
    check("R4 full cleared", rx_full, 0);
    check("R4 data held", rx_data, 8'hA5);
  endtask

  task automatic t_overflow();
    do_reset();
    put_byte(8'h11); put_byte(8'h22);
    check("R2 ovr set", ovr, 1);
    check("R2 data kept", rx_data, 8'h11);
    put_byte(8'h33);
    check("R3 data kept", rx_data, 8'h11);
    check("R3 full stays", rx_full, 1);
    rd_stat(); rd_data();
    check("R5 ovr cleared", ovr, 0);
    check("R4 full cleared", rx_full, 0);
    put_byte(8'h44);
    check("R1 capture after clear", rx_data, 8'h44);
  endtask

  task automatic t_missed();
    do_reset();
    put_byte(8'h01); rd_stat(); rd_data();
    put_byte(8'h02); rd_stat();
    put_byte(8'h03);
    check("R2 ovr between reads", ovr, 1);
    rd_data();
    check("R5 full cleared", rx_full, 0);
    check("R5 ovr survives", ovr, 1);
    put_byte(8'h04);
    check("R3 no full while ovr", rx_full, 0);
    check("R3 byte lost", rx_data, 8'h02);
    rd_stat(); rd_data();
    check("R5 ovr cleared by armed pair", ovr, 0);
  endtask

  task automatic t_collide();
    do_reset();
    put_byte(8'h5A); rd_stat();
    byte_in = 8'hC3; byte_done = 1; data_rd = 1; tick();
    byte_done = 0; data_rd = 0;
    check("R10 full", rx_full, 1);
    check("R10 data", rx_data, 8'hC3);
    check("R10 no ovr", ovr, 0);
  endtask

  task automatic t_fault();
    do_reset();
    fault_det = 1; tick(); fault_det = 0;
    check("R6 disabled", fault, 0);
    fault_en = 1;
    fault_det = 1; tick(); fault_det = 0;
    check("R6 set", fault, 1);
    wr_ctrl();
    check("R7 bare write keeps", fault, 1);
    rd_stat(); wr_ctrl();
    check("R7 cleared", fault, 0);
  endtask

  task automatic t_irq();
    do_reset();
    rx_ie = 1;
    put_byte(8'h10); tick();
    check("R8 rx irq", cpu_irq, 1);
    check("R9 no dma", dma_req, 0);
    dma_sel = 1; tick(); tick();
    check("R9 dma req", dma_req, 1);
    check("R8 cpu off in dma", cpu_irq, 0);
    rx_ie = 0; dma_sel = 0;
    put_byte(8'h20); tick();
    check("R8 ovr masked", cpu_irq, 0);
    err_ie = 1; tick(); tick();
    check("R8 ovr irq", cpu_irq, 1);
    do_reset();
    err_ie = 1; fault_en = 1;
    fault_det = 1; tick(); fault_det = 0; tick();
    check("R8 fault irq", cpu_irq, 1);
    err_ie = 0; tick(); tick();
    check("R8 fault masked", cpu_irq, 0);
  endtask

  initial begin
    t_reset();
    t_capture_clear();
    t_overflow();
    t_missed();
    t_collide();
    t_fault();
    t_irq();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule